// File: doc/BRIEF.md
# MDIO Management Frame Launcher

This block starts serial management transactions toward an external PHY. Software sees two registers on a minimal write/read bus. One holds a 32-bit frame image. The other holds a clock divider value. Storing a frame image raises an internal pending request. The request turns into a transaction on the serial management pins only while the divider is non-zero and no other transaction is running. As a result, the image and the divider can be programmed in either order.

While a transaction runs, the block derives the management clock from the system clock using the divider. It sends a run of preamble ones and then the image, most significant bit first. The image's opcode field selects a read or a write. For a read, the block releases the data pin at the turnaround bits, shifts in sixteen bits from the PHY and writes them into the low half of the image register. A one-cycle done pulse marks the end of every transaction.

Top module: `mgmt_frame_launcher`

## Requirements
- R1: A write to address 0 while the divider is non-zero, nothing is pending and the block is idle makes `busy` rise on the second rising clock edge after the write edge.
- R2: While the divider register reads zero, no transaction starts: `busy` stays low and `mdc` stays low.
- R3: An image written while the divider is zero is held. A later write of a non-zero divider to address 1 launches a transaction that carries that held image.
- R4: During a transaction, `mdc` starts low and has a period of exactly 2 × divider system clock cycles. The divider value is captured when the transaction launches, so later divider writes do not change a running transaction.
- R5: Each transaction sends 32 ones followed by the 32-bit image, most significant bit first. `mdio_o` changes only on falling `mdc` edges and is valid at every rising `mdc` edge.
- R6: When image bits 29:28 equal 2'b10 (read), `mdio_oe` drops at the first turnaround bit (image bit 17, the 47th rising edge) and stays low to the end. The 16 bits sampled on the last 16 rising edges, first bit as MSB, replace image bits 15:0. Bits 31:16 are kept.
- R7: `done` is high for exactly one system clock cycle, beginning in the cycle after the final `mdc` falling edge. In that cycle `busy` is already low and `mdc` is low.
- R8: An image written while a transaction is busy is stored. It launches in the cycle after `done`, provided the divider is non-zero.
- R9: `bus_rdata` shows the image register when `bus_addr` is 0. It shows the divider, zero-extended from bits 7:0 of the written word, when `bus_addr` is 1.
- R10: When a read completes while another image is queued, the captured bits are discarded and the queued image stays intact.
- R11: After reset, `busy`, `done`, `mdc` and `mdio_oe` are low, the divider reads 0 and nothing is pending. The image register has no defined reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 image, 1 divider |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data driven toward the PHY |
| mdio_oe | output | 1 | Output enable for `mdio_o` |
| mdio_i | input | 1 | Management data returned by the PHY |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |

## Verification
Two events can land on the same clock edge: the end of a read transaction, which wants to write captured bits into the image register, and a queued image written by software during that read. The bench provokes this by starting a read at the fastest divider and writing a second image while `busy` is high. At the `done` cycle it reads the image register and expects the queued image untouched, not the PHY data. The queued image must then go out as the next frame, bit for bit. A related overlap is also exercised: a divider write of zero during a transaction, which must change neither the running clock period nor the frame content.

// File: rtl/mfl_pkg.sv
`timescale 1ns/1ps
package mfl_pkg;
  // register select values on the bus
  localparam logic SEL_IMAGE = 1'b0;
  localparam logic SEL_SPEED = 1'b1;
  // opcode value that marks a read transaction
  localparam logic [1:0] OP_READ = 2'b10;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PRE  = 2'd1,
    PH_BODY = 2'd2
  } phase_e;
endpackage

// File: rtl/mfl_rst_sync.sv
`timescale 1ns/1ps
module mfl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic arst_n
);
  logic s1_q;
  logic s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign arst_n = s2_q;
endmodule

// File: rtl/mfl_regs.sv
`timescale 1ns/1ps
module mfl_regs #(
  parameter int DIV_W   = 8,
  parameter int FRAME_W = 32,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               arst_n,
  input  logic               wr_en,
  input  logic               wr_sel,
  input  logic [FRAME_W-1:0] wr_data,
  input  logic               rd_sel,
  input  logic               launch,
  input  logic               cap_valid,
  input  logic [DATA_W-1:0]  cap_data,
  output logic [FRAME_W-1:0] image,
  output logic [DIV_W-1:0]   speed,
  output logic               pend,
  output logic [FRAME_W-1:0] rd_data
);
  import mfl_pkg::*;

  localparam int PAD_W = FRAME_W - DIV_W;

  logic [FRAME_W-1:0] image_q, image_n;
  logic               image_en;
  logic [DIV_W-1:0]   speed_q, speed_n;
  logic               pend_q, pend_n;
  logic               wr_img, wr_spd;

  assign wr_img = wr_en && (wr_sel == SEL_IMAGE);
  assign wr_spd = wr_en && (wr_sel == SEL_SPEED);

  // image register: software write wins, captured read data only when nothing queued
  always_comb begin
    image_en = wr_img || (cap_valid && !pend_q);
    if (wr_img) image_n = wr_data;
    else        image_n = {image_q[FRAME_W-1:DATA_W], cap_data};
  end

  always_comb begin
    speed_n = speed_q;
    if (wr_spd) speed_n = wr_data[DIV_W-1:0];
  end

  always_comb begin
    pend_n = pend_q;
    if (wr_img)      pend_n = 1'b1;
    else if (launch) pend_n = 1'b0;
  end

  // no defined reset value for the image
  always_ff @(posedge clk) begin
    if (image_en) image_q <= image_n;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      speed_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      speed_q <= speed_n;
      pend_q  <= pend_n;
    end
  end

  assign image   = image_q;
  assign speed   = speed_q;
  assign pend    = pend_q;
  assign rd_data = (rd_sel == SEL_SPEED) ? {{PAD_W{1'b0}}, speed_q} : image_q;
endmodule

// File: rtl/mfl_mdc_gen.sv
`timescale 1ns/1ps
module mfl_mdc_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             launch,
  input  logic             run,
  input  logic [DIV_W-1:0] div_in,
  output logic             mdc,
  output logic             rise,
  output logic             fall
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt_q, cnt_n;
  logic [DIV_W-1:0] div_q, div_n;
  logic             mdc_q, mdc_n;
  logic             wrap;

  assign wrap = run && (cnt_q == (div_q - ONE));
  assign rise = wrap && !mdc_q;
  assign fall = wrap && mdc_q;

  always_comb begin
    cnt_n = cnt_q;
    div_n = div_q;
    mdc_n = mdc_q;
    if (launch) begin
      cnt_n = '0;
      mdc_n = 1'b0;
      div_n = div_in;
    end else if (run) begin
      if (wrap) begin
        cnt_n = '0;
        mdc_n = !mdc_q;
      end else begin
        cnt_n = cnt_q + ONE;
      end
    end else begin
      cnt_n = '0;
      mdc_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q <= '0;
      div_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      div_q <= div_n;
      mdc_q <= mdc_n;
    end
  end

  assign mdc = mdc_q;
endmodule

// File: rtl/mfl_seq.sv
`timescale 1ns/1ps
module mfl_seq #(
  parameter int PRE_LEN = 32,
  parameter int FRAME_W = 32,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               arst_n,
  input  logic               launch,
  input  logic [FRAME_W-1:0] image,
  input  logic               rise,
  input  logic               fall,
  input  logic               mdio_i,
  output logic               busy,
  output logic               done,
  output logic               mdio_o,
  output logic               mdio_oe,
  output logic               cap_valid,
  output logic [DATA_W-1:0]  cap_data
);
  import mfl_pkg::*;

  localparam int TOTAL  = PRE_LEN + FRAME_W;
  localparam int IDX_W  = $clog2(TOTAL);
  localparam int OP_HI  = FRAME_W - 3;
  localparam int TA_OFF = FRAME_W - 2 - DATA_W;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL - 1);
  localparam logic [IDX_W-1:0] PRE_LAST = IDX_W'(PRE_LEN - 1);
  localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(PRE_LEN + TA_OFF);
  localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(TOTAL - DATA_W);
  localparam logic [IDX_W-1:0] IDX_ONE  = IDX_W'(1);

  phase_e             ph_q, ph_n;
  logic [IDX_W-1:0]   idx_q, idx_n;
  logic [FRAME_W-1:0] sh_q, sh_n;
  logic [DATA_W-1:0]  cap_q, cap_n;
  logic               rd_q, rd_n;
  logic               done_q, done_n;
  logic               at_last;

  assign at_last = fall && (idx_q == LAST_IDX);

  always_comb begin
    ph_n   = ph_q;
    idx_n  = idx_q;
    sh_n   = sh_q;
    cap_n  = cap_q;
    rd_n   = rd_q;
    done_n = 1'b0;
    if (launch) begin
      ph_n  = PH_PRE;
      idx_n = '0;
      sh_n  = image;
      cap_n = '0;
      rd_n  = (image[OP_HI -: 2] == OP_READ);
    end else begin
      if (rise && rd_q && (idx_q >= DAT_IDX))
        cap_n = {cap_q[DATA_W-2:0], mdio_i};
      if (fall) begin
        if (at_last) begin
          ph_n   = PH_IDLE;
          done_n = 1'b1;
        end else begin
          idx_n = idx_q + IDX_ONE;
          if (ph_q == PH_BODY)  sh_n = {sh_q[FRAME_W-2:0], 1'b0};
          if (idx_q == PRE_LAST) ph_n = PH_BODY;
        end
      end
    end
  end

  // datapath registers carry no reset
  always_ff @(posedge clk) begin
    sh_q  <= sh_n;
    cap_q <= cap_n;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      ph_q   <= PH_IDLE;
      idx_q  <= '0;
      rd_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_n;
      idx_q  <= idx_n;
      rd_q   <= rd_n;
      done_q <= done_n;
    end
  end

  assign busy      = (ph_q != PH_IDLE);
  assign done      = done_q;
  assign mdio_o    = (ph_q == PH_BODY) ? sh_q[FRAME_W-1] : 1'b1;
  assign mdio_oe   = busy && !(rd_q && (idx_q >= TA_IDX));
  assign cap_valid = at_last && rd_q;
  assign cap_data  = cap_q;
endmodule

// File: rtl/mgmt_frame_launcher.sv
`timescale 1ns/1ps
module mgmt_frame_launcher #(
  parameter int DIV_W   = 8,
  parameter int PRE_LEN = 32,
  parameter int FRAME_W = 32,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_addr,
  input  logic [FRAME_W-1:0] bus_wdata,
  output logic [FRAME_W-1:0] bus_rdata,
  output logic               mdc,
  output logic               mdio_o,
  output logic               mdio_oe,
  input  logic               mdio_i,
  output logic               busy,
  output logic               done
);
  logic               arst_n;
  logic [FRAME_W-1:0] image_w;
  logic [DIV_W-1:0]   speed_w;
  logic               pend_w;
  logic               launch_w;
  logic               rise_w, fall_w;
  logic               cap_valid_w;
  logic [DATA_W-1:0]  cap_data_w;

  assign launch_w = pend_w && (speed_w != '0) && !busy;

  mfl_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .arst_n (arst_n)
  );

  mfl_regs #(.DIV_W(DIV_W), .FRAME_W(FRAME_W), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .arst_n    (arst_n),
    .wr_en     (bus_wr),
    .wr_sel    (bus_addr),
    .wr_data   (bus_wdata),
    .rd_sel    (bus_addr),
    .launch    (launch_w),
    .cap_valid (cap_valid_w),
    .cap_data  (cap_data_w),
    .image     (image_w),
    .speed     (speed_w),
    .pend      (pend_w),
    .rd_data   (bus_rdata)
  );

  mfl_mdc_gen #(.DIV_W(DIV_W)) u_mdc (
    .clk    (clk),
    .arst_n (arst_n),
    .launch (launch_w),
    .run    (busy),
    .div_in (speed_w),
    .mdc    (mdc),
    .rise   (rise_w),
    .fall   (fall_w)
  );

  mfl_seq #(.PRE_LEN(PRE_LEN), .FRAME_W(FRAME_W), .DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .arst_n    (arst_n),
    .launch    (launch_w),
    .image     (image_w),
    .rise      (rise_w),
    .fall      (fall_w),
    .mdio_i    (mdio_i),
    .busy      (busy),
    .done      (done),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .cap_valid (cap_valid_w),
    .cap_data  (cap_data_w)
  );
endmodule

// File: rtl/mfl_checker.sv
`timescale 1ns/1ps
module mfl_checker #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             arst_n,
  input logic             bus_wr,
  input logic             bus_addr,
  input logic             busy,
  input logic             pend,
  input logic [DIV_W-1:0] speed,
  input logic             mdc,
  input logic             mdio_oe,
  input logic             done
);
  p_launch_r1: assert property (@(posedge clk) disable iff (!arst_n)
    (bus_wr && !bus_addr && !busy && !pend && speed != '0) |=> (!busy ##1 busy));

  p_no_start_r2: assert property (@(posedge clk) disable iff (!arst_n)
    (!busy && speed == '0) |=> !busy);

  p_mdc_quiet_r2: assert property (@(posedge clk) disable iff (!arst_n)
    !busy |-> !mdc);

  p_pend_held_r3: assert property (@(posedge clk) disable iff (!arst_n)
    (pend && speed == '0 && !(bus_wr && bus_addr)) |=> pend);

  p_oe_released_r6: assert property (@(posedge clk) disable iff (!arst_n)
    (busy && !mdio_oe) |=> (!mdio_oe || !busy));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!arst_n)
    done |=> !done);

  p_done_at_end_r7: assert property (@(posedge clk) disable iff (!arst_n)
    done |-> ($fell(busy) && !mdc));

  p_queue_go_r8: assert property (@(posedge clk) disable iff (!arst_n)
    (done && pend && speed != '0) |=> busy);
endmodule

bind mgmt_frame_launcher mfl_checker #(.DIV_W(DIV_W)) u_chk (
  .clk      (clk),
  .arst_n   (arst_n),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .busy     (busy),
  .pend     (pend_w),
  .speed    (speed_w),
  .mdc      (mdc),
  .mdio_oe  (mdio_oe),
  .done     (done)
);

// File: tb/tb_mgmt_frame_launcher.sv
`timescale 1ns/1ps
module tb_mgmt_frame_launcher;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_addr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe, busy, done;
  logic        mdio_i = 1'b0;

  int checks = 0;
  int failures = 0;

  always #2 clk = !clk;

  mgmt_frame_launcher dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i), .busy(busy), .done(done)
  );

  // monitor / PHY model, all at the falling system clock edge
  logic [63:0] got_o, got_oe;
  logic [15:0] phy_word = '0;
  int rise_cnt = 0, total_rises = 0, ncyc = 0, last_rise = -1;
  int per_min = 1000, per_max = 0;
  logic busy_d = 1'b0, mdc_d = 1'b0;

  always @(negedge clk) begin
    ncyc = ncyc + 1;
    if (busy && !busy_d) begin
      rise_cnt = 0; got_o = '0; got_oe = '0;
      per_min = 1000; per_max = 0; last_rise = -1;
    end
    if (mdc && !mdc_d) begin
      if (rise_cnt < 64) begin
        got_o[rise_cnt]  = mdio_o;
        got_oe[rise_cnt] = mdio_oe;
      end
      if (last_rise >= 0) begin
        if (ncyc - last_rise < per_min) per_min = ncyc - last_rise;
        if (ncyc - last_rise > per_max) per_max = ncyc - last_rise;
      end
      last_rise = ncyc;
      rise_cnt = rise_cnt + 1;
      total_rises = total_rises + 1;
    end
    if (!mdc && mdc_d && rise_cnt >= 48 && rise_cnt < 64)
      mdio_i = phy_word[15 - (rise_cnt - 48)];
    busy_d = busy;
    mdc_d = mdc;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit is_read(input logic [31:0] img);
    return img[29:28] == 2'b10;
  endfunction

  function automatic logic exp_bit(input logic [31:0] img, input int b);
    return (b < 32) ? 1'b1 : img[31 - (b - 32)];
  endfunction

  function automatic logic exp_oe(input logic [31:0] img, input int b);
    return !(is_read(img) && b >= 46);
  endfunction

  function automatic logic [31:0] exp_final(input logic [31:0] img, input logic [15:0] phy);
    return is_read(img) ? {img[31:16], phy} : img;
  endfunction

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 1'b0;
  endtask

  task automatic rd_speed(output logic [31:0] v);
    bus_addr = 1'b1; #0.5; v = bus_rdata; bus_addr = 1'b0; #0.5;
  endtask

  task automatic wait_frame(input logic [31:0] img, input int spd, input logic [31:0] final_exp, input string tag);
    int t = 0;
    logic bits_ok = 1'b1, oe_ok = 1'b1;
    do begin @(negedge clk); t++; end while (!done && t < 5000);
    chk(done === 1'b1, {tag, " R7 done seen"}, 32'(done), 32'd1);
    chk(busy === 1'b0 && mdc === 1'b0, {tag, " R7 idle at done"}, {busy, mdc}, 32'd0);
    for (int b = 0; b < 64; b++) begin
      if (got_oe[b] !== exp_oe(img, b)) oe_ok = 1'b0;
      if (exp_oe(img, b) && got_o[b] !== exp_bit(img, b)) bits_ok = 1'b0;
    end
    chk(rise_cnt == 64, {tag, " R5 rise count"}, 32'(rise_cnt), 32'd64);
    chk(bits_ok, {tag, " R5 frame bits"}, got_o[63:32], img);
    chk(oe_ok, {tag, " R6 oe pattern"}, got_oe[63:32], 32'(is_read(img)));
    chk(per_min == 2*spd && per_max == 2*spd, {tag, " R4 mdc period"}, 32'(per_max), 32'(2*spd));
    chk(bus_rdata === final_exp, {tag, " R6/R9 image readback"}, bus_rdata, final_exp);
    @(negedge clk);
    chk(done === 1'b0, {tag, " R7 single pulse"}, 32'(done), 32'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v, img_a, img_b;
    int r0;
    void'($urandom(32'h5eed_1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    rd_speed(v);
    chk(busy === 1'b0 && done === 1'b0 && mdc === 1'b0 && mdio_oe === 1'b0,
        "R11 outputs after reset", {busy, done, mdc, mdio_oe}, 32'd0);
    chk(v === 32'd0, "R11 divider after reset", v, 32'd0);

    // R2 / R3: image with zero divider stays pending
    img_a = 32'h6A5C_0000 | 32'h0002_1234;
    img_a[29:28] = 2'b10;
    phy_word = 16'hC3A5;
    wr(1'b0, img_a);
    r0 = total_rises;
    repeat (80) @(negedge clk);
    chk(busy === 1'b0 && total_rises == r0, "R2 no frame with zero divider", 32'(total_rises - r0), 32'd0);
    wr(1'b1, 32'hFFFF_FF03);
    rd_speed(v);
    chk(v === 32'd3, "R9 divider readback zero-extended", v, 32'd3);
    wait_frame(img_a, 3, exp_final(img_a, phy_word), "R3 held image");

    // R1 launch timing
    img_b = 32'h5123_4567;
    wr(1'b0, img_b);
    chk(busy === 1'b0, "R1 not yet busy", 32'(busy), 32'd0);
    @(negedge clk);
    chk(busy === 1'b1, "R1 busy on second edge", 32'(busy), 32'd1);
    wait_frame(img_b, 3, img_b, "R1 frame");

    // R4 divider captured at launch; zero write mid-frame
    wr(1'b1, 32'd2);
    img_b = 32'h5F0F_A0A0;
    wr(1'b0, img_b);
    repeat (20) @(negedge clk);
    wr(1'b1, 32'd0);
    wait_frame(img_b, 2, img_b, "R4 latched divider");
    r0 = total_rises;
    repeat (60) @(negedge clk);
    chk(busy === 1'b0 && total_rises == r0, "R2 idle after zero divider", 32'(total_rises - r0), 32'd0);

    // R8 / R10: queue during a read, capture must not overwrite queued image
    wr(1'b1, 32'd1);
    img_a = 32'h6B00_0000; img_a[29:28] = 2'b10;
    img_b = 32'h5ACE_BEEF; img_b[29:28] = 2'b01;
    phy_word = 16'h1F2E;
    wr(1'b0, img_a);
    wr(1'b0, img_b);
    wait_frame(img_a, 1, img_b, "R10 queued image kept");
    wait_frame(img_b, 1, img_b, "R8 queued frame");

    // random frames
    for (int i = 0; i < 12; i++) begin
      int spd;
      logic [31:0] img;
      spd = 1 + ($urandom % 3);
      img = $urandom;
      img[29:28] = ($urandom % 2) ? 2'b10 : 2'b01;
      phy_word = 16'($urandom);
      wr(1'b1, 32'(spd));
      wr(1'b0, img);
      wait_frame(img, spd, exp_final(img, phy_word), "R5 random");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule